// File: doc/BRIEF.md
# Filtered Battery-Voltage Peak and Drop Detector

This block watches the voltage of a battery under fast charge and raises a termination flag once the voltage has passed its peak and begun to fall. The voltage reaches it as unsigned codes from an external converter, each with a valid strobe. The block never judges a single code. When a sample is requested it averages a run of consecutive converter codes into one sample. The averaging window is long enough to smooth out supply-line ripple. Requests come from a free-running interval timer, or from short pulses on the charge-inhibit line when a host wants sampling locked to its own events.

The detector keeps the highest averaged sample seen since the history was last started. It flags termination when a newer sample sits below that peak by at least a threshold, and the threshold depends on the timer-mode select. A coarse threshold suits the negative-slope method and a fine one suits peak detection. The drop test is suppressed during a hold-off period after each fast-charge start, and for any sample outside a valid voltage window. Holding the inhibit line high for a long time erases the history. The charge sequencer clears the flag at the start of each new cycle.

Top module: `vdrop_detect`

## Requirements
- R1: After reset, `term_o` is 0.
- R2: A sample is the integer floor of the mean of the first N converter codes strobed after a sample request, where N = 2^LOG2_SLOW when `tm_sel_i` is 2'b00 (low) or 2'b01 (mid), and 2^LOG2_FAST when `tm_sel_i[1]` is 1 (2'b10 or 2'b11, high). No sample is formed until all N codes have arrived.
- R3: A new sample that lies below the stored peak by DROP_FAST codes or more (high select), or by DROP_SLOW codes or more (low or mid select), sets `term_o`. A smaller drop leaves the flag unchanged. A sample above the peak becomes the new peak.
- R4: The drop test applies only to samples strictly between VMIN and VMAX. Samples outside that range still update the peak.
- R5: When sampling is not synchronised, a sample request is issued on every FREE_TICKS-th `tick_i` pulse.
- R6: If `inh_i` is high for 1 to SYNC_MAX_CLK clock cycles and then falls, a sample request is issued and sampling becomes synchronised, which stops the free-running requests. Synchronisation lapses after more than WIN_SLOW (low or mid) or WIN_FAST (high) ticks pass without such a pulse. The next free-running request then comes FREE_TICKS ticks after the lapse.
- R7: If `inh_i` stays high for more than CLR_MIN_CLK cycles, the stored peak is erased, and the next sample starts a new history.
- R8: An `inh_i` high period longer than SYNC_MAX_CLK and no longer than CLR_MIN_CLK cycles neither requests a sample nor erases the history.
- R9: A `chg_start_i` pulse erases the history and disables the drop test for HOLD_LOW, HOLD_MID or HOLD_HIGH ticks, chosen by the low, mid or high select.
- R10: `term_o` stays set until `term_clr_i` is asserted. A clear takes effect at the next clock edge and wins over a simultaneous set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| adc_code_i | input | CODE_W | Unsigned battery-voltage code from the converter |
| adc_vld_i | input | 1 | Strobe marking a valid converter code |
| inh_i | input | 1 | Charge-inhibit line; short pulses request samples, long highs erase history |
| tm_sel_i | input | 2 | Timer-mode select: 00 low, 01 mid, 1x high |
| chg_start_i | input | 1 | One-cycle pulse at the start of fast charge |
| tick_i | input | 1 | Time-base tick for intervals, windows and hold-off |
| term_clr_i | input | 1 | Synchronous clear of the termination flag |
| term_o | output | 1 | Sticky termination flag |

## Verification
The bench builds the block with very short tick counts: a free-running interval of 8 ticks, sync windows of 6 and 3 ticks, and hold-offs of 6, 12 and 3 ticks. With these values the hold-off expiry, the sync lapse and the free-running request each take only a few ticks to reach. The pulse-width limits are 7 and 24 clocks, so short, middle and long inhibit pulses each take tens of cycles. The window runs from 1000 to 2000 codes. The drop thresholds are 12 and 3 codes, and the averaging depths are 32 and 16. This makes exact one-code differences at both thresholds observable, and it shows floor rounding as a one-code difference that decides the flag.

// File: rtl/vdrop_pkg.sv
package vdrop_pkg;

    // Timer-mode select encoding; bit 1 set means the coarse (fast-rate) mode.
    typedef enum logic [1:0] {
        SEL_LOW   = 2'b00,
        SEL_MID   = 2'b01,
        SEL_HIGH  = 2'b10,
        SEL_HIGH2 = 2'b11
    } tsel_e;

    // Events decoded from the inhibit line.
    typedef struct packed {
        logic sync_req;
        logic hist_clr;
    } inh_evt_t;

    function automatic logic sel_is_fast(input logic [1:0] sel);
        return sel[1];
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/vdrop_inh_classifier.sv
module vdrop_inh_classifier
    import vdrop_pkg::*;
#(
    parameter int SYNC_MAX_CLK = 3500,
    parameter int CLR_MIN_CLK  = 12000
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     inh_i,
    output inh_evt_t evt_o
);
    localparam int CW = $clog2(CLR_MIN_CLK + 2);

    logic [CW-1:0] wid;

    always_ff @(posedge clk) begin
        if (rst) begin
            wid   <= '0;
            evt_o <= '0;
        end else begin
            evt_o <= '0;
            if (inh_i) begin
                if (wid != CW'(CLR_MIN_CLK + 1)) wid <= wid + 1'b1;
                if (wid == CW'(CLR_MIN_CLK)) evt_o.hist_clr <= 1'b1;
            end else begin
                if (wid != '0 && wid <= CW'(SYNC_MAX_CLK)) evt_o.sync_req <= 1'b1;
                wid <= '0;
            end
        end
    end

    // R6: a sync request follows a falling edge of the inhibit line
    assert_sync_on_fall_R6: assert property (@(posedge clk) disable iff (rst)
        evt_o.sync_req |-> (!$past(inh_i) && $past(inh_i, 2)));

    // R7: a history erase only happens while the line is held high
    assert_clear_while_high_R7: assert property (@(posedge clk) disable iff (rst)
        evt_o.hist_clr |-> $past(inh_i));

endmodule

// File: rtl/vdrop_sample_sched.sv
module vdrop_sample_sched
    import vdrop_pkg::*;
#(
    parameter int FREE_TICKS = 17,
    parameter int WIN_SLOW   = 19,
    parameter int WIN_FAST   = 9
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick_i,
    input  logic       sync_req_i,
    input  logic [1:0] sel_i,
    output logic       req_o
);
    localparam int TMAX = imax(FREE_TICKS, imax(WIN_SLOW, WIN_FAST));
    localparam int TW   = $clog2(TMAX + 2);

    logic          synced;
    logic [TW-1:0] free_cnt;
    logic [TW-1:0] win_cnt;
    logic [TW-1:0] win_lim;

    always_comb win_lim = sel_is_fast(sel_i) ? TW'(WIN_FAST) : TW'(WIN_SLOW);

    always_ff @(posedge clk) begin
        if (rst) begin
            synced   <= 1'b0;
            free_cnt <= '0;
            win_cnt  <= '0;
            req_o    <= 1'b0;
        end else begin
            req_o <= 1'b0;
            if (sync_req_i) begin
                req_o    <= 1'b1;
                synced   <= 1'b1;
                win_cnt  <= '0;
                free_cnt <= '0;
            end else if (tick_i) begin
                if (synced) begin
                    if (win_cnt >= win_lim) begin
                        synced   <= 1'b0;
                        free_cnt <= '0;
                    end else begin
                        win_cnt <= win_cnt + 1'b1;
                    end
                end else if (free_cnt == TW'(FREE_TICKS - 1)) begin
                    req_o    <= 1'b1;
                    free_cnt <= '0;
                end else begin
                    free_cnt <= free_cnt + 1'b1;
                end
            end
        end
    end

    // R5: a request not caused by a sync pulse comes from a tick
    assert_free_on_tick_R5: assert property (@(posedge clk) disable iff (rst)
        (req_o && !$past(sync_req_i)) |-> $past(tick_i));

endmodule

// File: rtl/vdrop_averager.sv
module vdrop_averager
    import vdrop_pkg::*;
#(
    parameter int CODE_W    = 12,
    parameter int LOG2_SLOW = 5,
    parameter int LOG2_FAST = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              abort_i,
    input  logic [1:0]        sel_i,
    input  logic [CODE_W-1:0] code_i,
    input  logic              valid_i,
    output logic              samp_vld_o,
    output logic [CODE_W-1:0] samp_o
);
    localparam int LMAX = imax(LOG2_SLOW, LOG2_FAST);
    localparam int AW   = CODE_W + LMAX;
    localparam int CNTW = LMAX + 1;
    localparam int LGW  = $clog2(LMAX + 1);

    logic            busy;
    logic [LGW-1:0]  lg;
    logic [AW-1:0]   acc;
    logic [AW-1:0]   sum;
    logic [CNTW-1:0] cnt;
    logic [CNTW-1:0] last_idx;

    always_comb begin
        sum      = acc + AW'(code_i);
        last_idx = CNTW'((1 << lg) - 1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy       <= 1'b0;
            lg         <= '0;
            acc        <= '0;
            cnt        <= '0;
            samp_vld_o <= 1'b0;
            samp_o     <= '0;
        end else begin
            samp_vld_o <= 1'b0;
            if (start_i) begin
                busy <= 1'b1;
                acc  <= '0;
                cnt  <= '0;
                lg   <= sel_is_fast(sel_i) ? LGW'(LOG2_FAST) : LGW'(LOG2_SLOW);
            end else if (abort_i) begin
                busy <= 1'b0;
            end else if (busy && valid_i) begin
                if (cnt == last_idx) begin
                    samp_o     <= CODE_W'(sum >> lg);
                    samp_vld_o <= 1'b1;
                    busy       <= 1'b0;
                end else begin
                    acc <= sum;
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    // R2: a sample only completes on a converter strobe during collection
    assert_sample_needs_strobe_R2: assert property (@(posedge clk) disable iff (rst)
        samp_vld_o |-> ($past(valid_i) && $past(busy)));

endmodule

// File: rtl/vdrop_drop_judge.sv
module vdrop_drop_judge
    import vdrop_pkg::*;
#(
    parameter int CODE_W    = 12,
    parameter int DROP_FAST = 12,
    parameter int DROP_SLOW = 3,
    parameter int VMIN      = 1000,
    parameter int VMAX      = 2000,
    parameter int HOLD_LOW  = 150,
    parameter int HOLD_MID  = 300,
    parameter int HOLD_HIGH = 75
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_i,
    input  logic              start_i,
    input  logic              hist_clr_i,
    input  logic              clr_i,
    input  logic [1:0]        sel_i,
    input  logic              samp_vld_i,
    input  logic [CODE_W-1:0] samp_i,
    output logic              term_o
);
    localparam int HW = $clog2(imax(HOLD_LOW, imax(HOLD_MID, HOLD_HIGH)) + 1);

    logic [HW-1:0]     hold_cnt;
    logic [HW-1:0]     hold_load;
    logic [CODE_W-1:0] peak;
    logic              have_peak;
    logic [CODE_W-1:0] drop;
    logic [CODE_W-1:0] thr;
    logic              in_range;
    logic              fire;

    always_comb begin
        unique case (tsel_e'(sel_i))
            SEL_LOW: hold_load = HW'(HOLD_LOW);
            SEL_MID: hold_load = HW'(HOLD_MID);
            default: hold_load = HW'(HOLD_HIGH);
        endcase
        thr      = sel_is_fast(sel_i) ? CODE_W'(DROP_FAST) : CODE_W'(DROP_SLOW);
        drop     = peak - samp_i;
        in_range = (samp_i > CODE_W'(VMIN)) && (samp_i < CODE_W'(VMAX));
        fire     = samp_vld_i && have_peak && (samp_i <= peak) && (hold_cnt == '0)
                   && in_range && (drop >= thr) && !start_i && !hist_clr_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_cnt  <= '0;
            peak      <= '0;
            have_peak <= 1'b0;
            term_o    <= 1'b0;
        end else begin
            if (start_i)                        hold_cnt <= hold_load;
            else if (tick_i && hold_cnt != '0)  hold_cnt <= hold_cnt - 1'b1;

            if (start_i || hist_clr_i) begin
                have_peak <= 1'b0;
            end else if (samp_vld_i && (!have_peak || samp_i > peak)) begin
                peak      <= samp_i;
                have_peak <= 1'b1;
            end

            if (clr_i)     term_o <= 1'b0;
            else if (fire) term_o <= 1'b1;
        end
    end

    // R3: the flag only rises right after a completed sample
    assert_rise_needs_sample_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(term_o) |-> $past(samp_vld_i));

    // R4: the sample that raised the flag lay inside the valid window
    assert_rise_in_window_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(term_o) |-> ($past(samp_i) > CODE_W'(VMIN) && $past(samp_i) < CODE_W'(VMAX)));

    // R9: no flag while the hold-off counter runs
    assert_holdoff_blocks_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(term_o) |-> ($past(hold_cnt) == '0));

    // R10: clear wins, and the flag otherwise stays set
    assert_clear_wins_R10: assert property (@(posedge clk) disable iff (rst)
        clr_i |=> !term_o);
    assert_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        (term_o && !clr_i) |=> term_o);

endmodule

// File: rtl/vdrop_detect.sv
module vdrop_detect
    import vdrop_pkg::*;
#(
    parameter int CODE_W       = 12,
    parameter int LOG2_SLOW    = 5,
    parameter int LOG2_FAST    = 4,
    parameter int DROP_FAST    = 12,
    parameter int DROP_SLOW    = 3,
    parameter int VMIN         = 1000,
    parameter int VMAX         = 2000,
    parameter int FREE_TICKS   = 17,
    parameter int WIN_SLOW     = 19,
    parameter int WIN_FAST     = 9,
    parameter int HOLD_LOW     = 150,
    parameter int HOLD_MID     = 300,
    parameter int HOLD_HIGH    = 75,
    parameter int SYNC_MAX_CLK = 3500,
    parameter int CLR_MIN_CLK  = 12000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CODE_W-1:0] adc_code_i,
    input  logic              adc_vld_i,
    input  logic              inh_i,
    input  logic [1:0]        tm_sel_i,
    input  logic              chg_start_i,
    input  logic              tick_i,
    input  logic              term_clr_i,
    output logic              term_o
);
    inh_evt_t          evt;
    logic              req;
    logic              samp_vld;
    logic [CODE_W-1:0] samp;

    vdrop_inh_classifier #(
        .SYNC_MAX_CLK (SYNC_MAX_CLK),
        .CLR_MIN_CLK  (CLR_MIN_CLK)
    ) u_classifier (
        .clk   (clk),
        .rst   (rst),
        .inh_i (inh_i),
        .evt_o (evt)
    );

    vdrop_sample_sched #(
        .FREE_TICKS (FREE_TICKS),
        .WIN_SLOW   (WIN_SLOW),
        .WIN_FAST   (WIN_FAST)
    ) u_sched (
        .clk        (clk),
        .rst        (rst),
        .tick_i     (tick_i),
        .sync_req_i (evt.sync_req),
        .sel_i      (tm_sel_i),
        .req_o      (req)
    );

    vdrop_averager #(
        .CODE_W    (CODE_W),
        .LOG2_SLOW (LOG2_SLOW),
        .LOG2_FAST (LOG2_FAST)
    ) u_avg (
        .clk        (clk),
        .rst        (rst),
        .start_i    (req),
        .abort_i    (evt.hist_clr),
        .sel_i      (tm_sel_i),
        .code_i     (adc_code_i),
        .valid_i    (adc_vld_i),
        .samp_vld_o (samp_vld),
        .samp_o     (samp)
    );

    vdrop_drop_judge #(
        .CODE_W    (CODE_W),
        .DROP_FAST (DROP_FAST),
        .DROP_SLOW (DROP_SLOW),
        .VMIN      (VMIN),
        .VMAX      (VMAX),
        .HOLD_LOW  (HOLD_LOW),
        .HOLD_MID  (HOLD_MID),
        .HOLD_HIGH (HOLD_HIGH)
    ) u_judge (
        .clk        (clk),
        .rst        (rst),
        .tick_i     (tick_i),
        .start_i    (chg_start_i),
        .hist_clr_i (evt.hist_clr),
        .clr_i      (term_clr_i),
        .sel_i      (tm_sel_i),
        .samp_vld_i (samp_vld),
        .samp_i     (samp),
        .term_o     (term_o)
    );

endmodule

// File: tb/vdrop_detect_bench.sv
module vdrop_detect_bench;

    localparam int CODE_W = 12;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [CODE_W-1:0] adc_code = '0;
    logic              adc_vld = 1'b0;
    logic              inh = 1'b0;
    logic [1:0]        tm_sel = 2'b00;
    logic              chg_start = 1'b0;
    logic              tick = 1'b0;
    logic              term_clr = 1'b0;
    logic              term;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    typedef struct {
        bit    exp;
        string tag;
    } item_t;
    item_t sb_q[$];

    always #2 clk = ~clk;

    vdrop_detect #(
        .CODE_W(CODE_W), .LOG2_SLOW(5), .LOG2_FAST(4),
        .DROP_FAST(12), .DROP_SLOW(3), .VMIN(1000), .VMAX(2000),
        .FREE_TICKS(8), .WIN_SLOW(6), .WIN_FAST(3),
        .HOLD_LOW(6), .HOLD_MID(12), .HOLD_HIGH(3),
        .SYNC_MAX_CLK(7), .CLR_MIN_CLK(24)
    ) u_vdrop_detect (
        .clk(clk), .rst(rst), .adc_code_i(adc_code), .adc_vld_i(adc_vld),
        .inh_i(inh), .tm_sel_i(tm_sel), .chg_start_i(chg_start),
        .tick_i(tick), .term_clr_i(term_clr), .term_o(term)
    );

    // Monitor: pops expected flag values and compares away from the active edge.
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            item_t it;
            it = sb_q.pop_front();
            checks++;
            if (term !== it.exp) begin
                failures++;
                $display("FAIL %s: term_o actual=%0b expected=%0b", it.tag, term, it.exp);
            end
        end
    end

    task automatic expect_term(input bit e, input string tag);
        item_t it;
        @(posedge clk);
        it.exp = e;
        it.tag = tag;
        sb_q.push_back(it);
        wait (sb_q.size() == 0);
        @(negedge clk);
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            tick = 1'b1;
            @(negedge clk);
            tick = 1'b0;
        end
        cyc(2);
    endtask

    task automatic inh_pulse(input int w);
        inh = 1'b1;
        cyc(w);
        inh = 1'b0;
        cyc(4);
    endtask

    task automatic feed(input int code, input int n);
        for (int i = 0; i < n; i++) begin
            adc_code = CODE_W'(code);
            adc_vld  = 1'b1;
            @(negedge clk);
        end
        adc_vld = 1'b0;
        cyc(3);
    endtask

    task automatic take(input int code, input int n);
        inh_pulse(3);
        feed(code, n);
    endtask

    task automatic start_chg(input logic [1:0] sel);
        tm_sel    = sel;
        chg_start = 1'b1;
        @(negedge clk);
        chg_start = 1'b0;
    endtask

    task automatic clear_flag();
        term_clr = 1'b1;
        @(negedge clk);
        term_clr = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        cyc(5);
        rst = 1'b0;
        cyc(2);
        expect_term(1'b0, "R1 reset state");

        // High select: coarse threshold
        start_chg(2'b10); ticks(3);
        take(1500, 16);  expect_term(1'b0, "R3 first sample sets peak");
        take(1489, 16);  expect_term(1'b0, "R3 drop 11 below coarse threshold");
        take(1488, 16);  expect_term(1'b1, "R3 drop 12 reaches coarse threshold");
        take(1495, 16);  expect_term(1'b1, "R10 flag sticky");
        clear_flag();    expect_term(1'b0, "R10 clear");

        // Floor rounding, depth 16
        start_chg(2'b10); ticks(3);
        inh_pulse(3); feed(1520, 8); feed(1521, 8);
        expect_term(1'b0, "R2 mixed sample");
        take(1509, 16);  expect_term(1'b0, "R2 mean floored to 1520, drop 11");
        take(1508, 16);  expect_term(1'b1, "R2 floored peak drop 12");
        clear_flag();

        // Depth 32 in low select
        start_chg(2'b00); ticks(6);
        take(1500, 32);
        take(1400, 16);  expect_term(1'b0, "R2 half of 32 codes forms no sample");
        feed(1400, 16);  expect_term(1'b1, "R2 sample completes at 32 codes");
        clear_flag();

        // Fine threshold in low select
        start_chg(2'b00); ticks(6);
        take(1500, 32);
        take(1498, 32);  expect_term(1'b0, "R3 drop 2 below fine threshold");
        take(1497, 32);  expect_term(1'b1, "R3 drop 3 reaches fine threshold");
        clear_flag();

        // Valid window
        start_chg(2'b10); ticks(3);
        take(2100, 16);
        take(2050, 16);  expect_term(1'b0, "R4 sample above window");
        take(2000, 16);  expect_term(1'b0, "R4 sample equal to upper bound");
        take(1999, 16);  expect_term(1'b1, "R4 sample just inside window");
        clear_flag();
        start_chg(2'b10); ticks(3);
        take(990, 16);
        take(950, 16);   expect_term(1'b0, "R4 sample below window");

        // Hold-off in mid select (12 ticks)
        start_chg(2'b01); ticks(11);
        take(1500, 32);
        take(1400, 32);  expect_term(1'b0, "R9 hold-off after 11 ticks");
        ticks(1);
        take(1400, 32);  expect_term(1'b1, "R9 test enabled after 12 ticks");
        clear_flag();

        // History erase and ignored middle pulse
        start_chg(2'b10); ticks(3);
        take(1500, 16);
        inh_pulse(30);
        take(1480, 16);  expect_term(1'b0, "R7 long inhibit erased peak");
        inh_pulse(15);
        feed(1460, 16);  expect_term(1'b0, "R8 middle pulse requested no sample");
        take(1460, 16);  expect_term(1'b1, "R8 middle pulse kept history");
        clear_flag();

        // Sync lapse and free-running request
        start_chg(2'b10); ticks(3);
        take(1500, 16);
        ticks(11);
        feed(1480, 16);  expect_term(1'b0, "R6 no request before free interval after lapse");
        ticks(1);
        feed(1480, 16);  expect_term(1'b1, "R5 free-running request sampled");
        clear_flag();

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule